// File: doc/BRIEF.md
# Key-Protected Reset Request Controller

This block is a small register window. Software uses it to ask the power logic for one of three actions: a shutdown, a power cycle or a warm reset. Each action leaves the block as a single-cycle pulse on its own output. The sequencing that follows such a pulse happens outside this block.

A request is honoured only when two guards are both satisfied.

- **Arm guard.** Each action has its own arm register, and software must write 1 to it beforehand.
- **Key guard.** A 16-bit unlock key must be written immediately before the control word. The key is single-use: the next control write consumes it, whether or not that write raises a pulse. Writing any other value to the key register locks the block again.

A cold reset has no output of its own. Software requests it through the warm reset bit.

Control writes carry their own mask. The upper half of the word selects which bits of the lower half are updated, so unrelated bits survive a write that targets one request bit. Request bits clear themselves one cycle after they are accepted. Every register can be read back through the same port.

Top module: `rst_req_guard`

## Requirements
- R1: After reset all pulse outputs are low, every arm register reads 0, the key register reads 0 (locked) and the control register reads 0.
- R2: The arm registers sit at byte offsets 0xC0 (shutdown), 0xC8 (power cycle) and 0xCC (warm reset). Writing any of them stores `wdata[0]`, and a read of the same offset returns that value in bit 0.
- R3: The key register sits at offset 0x10. A write whose lower 16 bits equal 0xAB18 unlocks the block, and a read then returns 1 in bit 0. A write of any other value locks the block, and the read returns 0.
- R4: A write to the control register (offset 0x14) while the block is locked changes no control bit and raises no pulse.
- R5: Every write to the control register leaves the block locked afterwards. A second control write without a fresh key is therefore ignored.
- R6: For a control write, `wdata[31:16]` is a per-bit write enable for `wdata[15:0]`. A control bit whose enable is 0 keeps its previous value, for example bit 11.
- R7: An accepted control write raises a pulse in the cycle after the write, lasting exactly one cycle. Control bit 0 drives the shutdown output, bit 3 the power-cycle output and bit 4 the warm-reset output. Several pulses may be raised together.
- R8: A request bit whose arm register holds 0 is dropped: no pulse is raised and the bit does not stay set.
- R9: Request bits clear themselves, so after the pulse cycle the control register reads 0 in bits 0, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for the addressed register |
| shutdown_pulse | output | 1 | One-cycle shutdown request |
| pwrcycle_pulse | output | 1 | One-cycle power-cycle request |
| warmrst_pulse | output | 1 | One-cycle warm-reset request |

## Verification
The hardest case to reach is a control write that is half valid: the key is present but only some of the targeted types are armed, or the key was cancelled by a wrong value or spent by an earlier control write.

The stimulus builds these states by interleaving several operations before each control write:

- arm and disarm writes;
- correct and wrong key writes;
- a consuming control write with no request bits set.

The scoreboard then expects exactly the armed subset of pulses in the single cycle after the write, and no pulses anywhere else. Masked writes that leave bit 11 alone, or clear it, show through readback that the write enables behave as described.

// File: rtl/rst_req_guard_pkg.sv
package rst_req_guard_pkg;

    localparam int NUM_KINDS = 3;

    localparam int KIND_SHDN = 0;
    localparam int KIND_PCYC = 1;
    localparam int KIND_WARM = 2;

    localparam logic [7:0] KEY_OFFSET  = 8'h10;
    localparam logic [7:0] CTRL_OFFSET = 8'h14;

    function automatic logic [7:0] arm_offset(input int kind);
        case (kind)
            KIND_SHDN: return 8'hC0;
            KIND_PCYC: return 8'hC8;
            default:   return 8'hCC;
        endcase
    endfunction

    function automatic int req_bit(input int kind);
        case (kind)
            KIND_SHDN: return 0;
            KIND_PCYC: return 3;
            default:   return 4;
        endcase
    endfunction

    typedef struct packed {
        logic open;
    } key_state_t;

    typedef struct packed {
        logic [NUM_KINDS-1:0] armed;
    } arm_state_t;

endpackage

// File: rtl/rst_req_guard_key.sv
module rst_req_guard_key #(
    parameter int          HALF_W    = 16,
    parameter logic [15:0] KEY_VALUE = 16'hAB18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              ctrl_wr,
    input  logic [HALF_W-1:0] wdata_lo,
    output logic              unlocked
);
    import rst_req_guard_pkg::*;

    key_state_t key_d, key_q;

    always_comb begin
        key_d = key_q;
        if (key_wr) begin
            key_d.open = (wdata_lo == HALF_W'(KEY_VALUE));
        end else if (ctrl_wr) begin
            key_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else begin
            key_q <= key_d;
        end
    end

    assign unlocked = key_q.open;

endmodule

// File: rtl/rst_req_guard_arm.sv
module rst_req_guard_arm #(
    parameter int ADDR_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 wbit,
    output logic [rst_req_guard_pkg::NUM_KINDS-1:0] armed
);
    import rst_req_guard_pkg::*;

    arm_state_t           arm_d, arm_q;
    logic [NUM_KINDS-1:0] hit;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_hit
        assign hit[k] = wr_en && (addr == ADDR_W'(arm_offset(k)));
    end

    always_comb begin
        arm_d = arm_q;
        for (int k = 0; k < NUM_KINDS; k++) begin
            if (hit[k]) begin
                arm_d.armed[k] = wbit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else begin
            arm_q <= arm_d;
        end
    end

    assign armed = arm_q.armed;

endmodule

// File: rtl/rst_req_guard_ctrl.sv
module rst_req_guard_ctrl #(
    parameter int DATA_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ctrl_wr,
    input  logic                                 unlocked,
    input  logic [rst_req_guard_pkg::NUM_KINDS-1:0] armed,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [DATA_W/2-1:0]                  word,
    output logic [rst_req_guard_pkg::NUM_KINDS-1:0] pulses
);
    import rst_req_guard_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] word;
    } ctrl_state_t;

    ctrl_state_t       ctrl_d, ctrl_q;
    logic [HALF_W-1:0] wmask;
    logic [HALF_W-1:0] wval;

    assign wmask = wdata[DATA_W-1:HALF_W];
    assign wval  = wdata[HALF_W-1:0];

    always_comb begin
        ctrl_d = ctrl_q;
        // request bits live for one cycle only
        for (int k = 0; k < NUM_KINDS; k++) begin
            ctrl_d.word[req_bit(k)] = 1'b0;
        end
        if (ctrl_wr && unlocked) begin
            ctrl_d.word = (ctrl_d.word & ~wmask) | (wval & wmask);
            for (int k = 0; k < NUM_KINDS; k++) begin
                ctrl_d.word[req_bit(k)] = ctrl_d.word[req_bit(k)] & armed[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_pulse
        assign pulses[k] = ctrl_q.word[req_bit(k)];
    end

    assign word = ctrl_q.word;

endmodule

// File: rtl/rst_req_guard.sv
module rst_req_guard #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter logic [15:0] KEY_VALUE = 16'hAB18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              shutdown_pulse,
    output logic              pwrcycle_pulse,
    output logic              warmrst_pulse
);
    import rst_req_guard_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    logic                 wr_en;
    logic                 key_wr;
    logic                 ctrl_wr;
    logic                 unlocked;
    logic [NUM_KINDS-1:0] armed;
    logic [NUM_KINDS-1:0] pulses;
    logic [HALF_W-1:0]    ctrl_word;

    assign wr_en   = bus_sel && bus_wr;
    assign key_wr  = wr_en && (bus_addr == ADDR_W'(KEY_OFFSET));
    assign ctrl_wr = wr_en && (bus_addr == ADDR_W'(CTRL_OFFSET));

    rst_req_guard_key #(
        .HALF_W    (HALF_W),
        .KEY_VALUE (KEY_VALUE)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .ctrl_wr  (ctrl_wr),
        .wdata_lo (bus_wdata[HALF_W-1:0]),
        .unlocked (unlocked)
    );

    rst_req_guard_arm #(
        .ADDR_W (ADDR_W)
    ) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (bus_addr),
        .wbit  (bus_wdata[0]),
        .armed (armed)
    );

    rst_req_guard_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .unlocked (unlocked),
        .armed    (armed),
        .wdata    (bus_wdata),
        .word     (ctrl_word),
        .pulses   (pulses)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == ADDR_W'(KEY_OFFSET)) begin
                bus_rdata[0] = unlocked;
            end else if (bus_addr == ADDR_W'(CTRL_OFFSET)) begin
                bus_rdata[HALF_W-1:0] = ctrl_word;
            end else begin
                for (int k = 0; k < NUM_KINDS; k++) begin
                    if (bus_addr == ADDR_W'(arm_offset(k))) begin
                        bus_rdata[0] = armed[k];
                    end
                end
            end
        end
    end

    assign shutdown_pulse = pulses[KIND_SHDN];
    assign pwrcycle_pulse = pulses[KIND_PCYC];
    assign warmrst_pulse  = pulses[KIND_WARM];

endmodule

// File: rtl/rst_req_guard_chk.sv
module rst_req_guard_chk (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 ctrl_wr,
    input logic                                 unlocked,
    input logic [rst_req_guard_pkg::NUM_KINDS-1:0] armed,
    input logic [rst_req_guard_pkg::NUM_KINDS-1:0] pulses
);

    AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulses) |=> ((pulses & $past(pulses)) == '0)); // R7

    AST_PULSE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulses & ~armed) == '0)); // R8

    AST_PULSE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulses) |-> $past(ctrl_wr && unlocked)); // R4

    AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !unlocked); // R5

endmodule

bind rst_req_guard rst_req_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (ctrl_wr),
    .unlocked (unlocked),
    .armed    (armed),
    .pulses   (pulses)
);

// File: tb/rst_req_guard_bench.sv
module rst_req_guard_bench;

    localparam logic [7:0] A_KEY  = 8'h10;
    localparam logic [7:0] A_CTRL = 8'h14;
    localparam logic [7:0] A_SHDN = 8'hC0;
    localparam logic [7:0] A_PCYC = 8'hC8;
    localparam logic [7:0] A_WARM = 8'hCC;
    localparam logic [31:0] GOOD_KEY = 32'h0000_AB18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        shutdown_pulse, pwrcycle_pulse, warmrst_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // scoreboard: expected pulse vector {warm, pcyc, shdn} per cycle
    int         q_cyc[$];
    logic [2:0] q_val[$];
    string      q_req[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    rst_req_guard u_rst_req_guard (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_sel        (bus_sel),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .shutdown_pulse (shutdown_pulse),
        .pwrcycle_pulse (pwrcycle_pulse),
        .warmrst_pulse  (warmrst_pulse)
    );

    // monitor
    always @(negedge clk) begin
        logic [2:0] got;
        if (rst_n) begin
            got = {warmrst_pulse, pwrcycle_pulse, shutdown_pulse};
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                logic [2:0] exp;
                string      req;
                exp = q_val.pop_front();
                req = q_req.pop_front();
                void'(q_cyc.pop_front());
                checks++;
                if (got !== exp) begin
                    errors++;
                    $display("FAIL %s pulses actual=%b expected=%b", req, got, exp);
                end
            end else if (got !== 3'b000) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected pulses actual=%b expected=000", got);
            end
        end
    end

    task automatic bus_write(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    // control write with expected pulse vector in the following cycle
    task automatic ctrl_write(input logic [31:0] data, input logic [2:0] exp, input string req);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = A_CTRL;
        bus_wdata = data;
        q_cyc.push_back(cyc + 1);
        q_val.push_back(exp);
        q_req.push_back(req);
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic bus_check(input logic [7:0] addr, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = addr;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%0h actual=0x%0h expected=0x%0h", req, addr, bus_rdata, exp);
        end
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_check(A_SHDN, 32'h0, "R1");
        bus_check(A_PCYC, 32'h0, "R1");
        bus_check(A_WARM, 32'h0, "R1");
        bus_check(A_KEY,  32'h0, "R1");
        bus_check(A_CTRL, 32'h0, "R1");

        // R2 arm registers
        bus_write(A_SHDN, 32'h1);
        bus_check(A_SHDN, 32'h1, "R2");
        bus_write(A_PCYC, 32'h2);
        bus_check(A_PCYC, 32'h0, "R2");

        // R4 locked control write ignored
        ctrl_write(32'hFFFF_0801, 3'b000, "R4");
        bus_check(A_CTRL, 32'h0, "R4");

        // R3 key handling
        bus_write(A_KEY, 32'h0000_1234);
        bus_check(A_KEY, 32'h0, "R3");
        bus_write(A_KEY, 32'hFFFF_AB18);
        bus_check(A_KEY, 32'h1, "R3");

        // R7 accepted shutdown, R5 consume, R9 self clear
        ctrl_write(32'hFFFF_0801, 3'b001, "R7");
        bus_check(A_KEY,  32'h0, "R5");
        bus_check(A_CTRL, 32'h0000_0800, "R9");

        // R8 unarmed power cycle; R6 bit 11 kept when unmasked
        bus_write(A_KEY, GOOD_KEY);
        ctrl_write(32'h0008_0008, 3'b000, "R8");
        bus_check(A_CTRL, 32'h0000_0800, "R6");

        // R7 two pulses at once
        bus_write(A_PCYC, 32'h1);
        bus_write(A_WARM, 32'h1);
        bus_write(A_KEY, GOOD_KEY);
        ctrl_write(32'hFFFF_0818, 3'b110, "R7");

        // R3 wrong key after good key relocks
        bus_write(A_KEY, GOOD_KEY);
        bus_write(A_KEY, 32'h0000_AB19);
        ctrl_write(32'hFFFF_0801, 3'b000, "R3");

        // R6 mask on bit 0 only
        bus_write(A_KEY, GOOD_KEY);
        ctrl_write(32'h0001_0019, 3'b001, "R6");
        bus_check(A_CTRL, 32'h0000_0800, "R6");

        // R8 disarmed shutdown, R6 bit 11 cleared under mask
        bus_write(A_SHDN, 32'h0);
        bus_write(A_KEY, GOOD_KEY);
        ctrl_write(32'hFFFF_0011, 3'b100, "R8");
        bus_check(A_CTRL, 32'h0, "R6");

        // R5 second control write without fresh key
        bus_write(A_KEY, GOOD_KEY);
        ctrl_write(32'hFFFF_0000, 3'b000, "R5");
        ctrl_write(32'hFFFF_0010, 3'b000, "R5");
        bus_check(A_KEY, 32'h0, "R5");

        repeat (4) @(negedge clk);
        if (q_cyc.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R7 pending expected pulses actual=%0d expected=0", q_cyc.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule